// File: doc/BRIEF.md
# Minimal 16-bit Execute Unit

This block carries out already-decoded MOV, ADD, SUB, CMP and JNE operations for a small 16-bit processor. It owns the eight 16-bit general registers, the instruction pointer and two condition flags, zero and sign. A decoder upstream presents one instruction record at a time on `instValid`, with every memory operand already turned into an address. The unit accepts the record in a cycle where `busy` is low, then sequences any memory read, the arithmetic, the register or flag update and any memory write on its own.

Memory is external, byte-wide and single-ported, with a read latency of one clock. A 16-bit operand uses two consecutive byte addresses, low byte first. The address width is a parameter, so addresses wrap at the end of memory. The architectural state is visible on output ports at all times.

Top module: `exec16_top`

## Requirements
- R1: After reset all eight registers, the instruction pointer, both flags, `busy` and `memWe` are zero.
- R2: Register code bit 3 set selects the 16-bit register given by bits 2:0. Those registers are in order AX, CX, DX, BX, SP, BP, SI, DI, and register i appears at `regsOut[16*i+15:16*i]`. Bit 3 clear selects a byte: bits 1:0 pick AX, CX, DX or BX, and bit 2 picks the high byte (set) or the low byte (clear). A byte write leaves the other byte of that register unchanged.
- R3: The operation is 16-bit if the destination is a register with code bit 3 set. If the destination is memory, the width comes from the source register when the source is a register (`srcKind` 0). Otherwise the width is 8 bits for `srcKind` 1 (imm8) and 16 bits for `srcKind` 2 (imm16). `srcKind` 3 is a memory source.
- R4: Op codes are 0 MOV, 1 ADD, 2 SUB, 3 CMP and 4 JNE. MOV, ADD and SUB write their result to the destination. CMP computes destination minus source, writes nothing and only changes the flags. MOV and JNE leave both flags unchanged.
- R5: ADD, SUB and CMP set the zero flag when the result, cut to the operation width, is zero. They set the sign flag to bit 15 of a 16-bit result or bit 7 of an 8-bit result.
- R6: Every instruction adds its length to the instruction pointer. JNE then also adds its sign-extended 8-bit offset, but only when the zero flag is clear. The instruction pointer changes only while the unit is busy.
- R7: A memory write puts out one byte per cycle. A 16-bit store writes the low byte at the address and then the high byte at the address plus one. An 8-bit store writes one byte.
- R8: Address plus one wraps modulo 2^`ADDR_W`, for both reads and writes.
- R9: `busy` rises in the cycle after a record is accepted. It stays high for 1 cycle, plus 2 cycles if a memory operand is read, plus 1 cycle per byte written. No record is accepted while it is high, and no register, flag or memory changes while it is low.
- R10: A 16-bit memory operand is read little-endian: the byte at the address is the low byte.
- R11: A loop that stores SI to address BP+SI for SI = 0, 2, 4 with BP = 1000, and then sums those words into BX, ends with BX = 6, SI = 6 and the zero flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| instValid | input | 1 | Record present; taken when `busy` is low |
| instOp | input | 3 | Operation code (R4) |
| instLen | input | 3 | Instruction length in bytes |
| dstIsReg | input | 1 | Destination is a register (else memory) |
| dstReg | input | 4 | Destination register code (R2) |
| dstAddr | input | ADDR_W | Destination memory address |
| srcKind | input | 2 | Source kind: register, imm8, imm16, memory |
| srcReg | input | 4 | Source register code |
| srcImm | input | 16 | Immediate value |
| srcAddr | input | ADDR_W | Source memory address |
| jmpOff | input | 8 | Signed branch offset |
| busy | output | 1 | Instruction in progress |
| memAddr | output | ADDR_W | Memory byte address |
| memWe | output | 1 | Memory byte write strobe |
| memWdata | output | 8 | Memory write byte |
| memRdata | input | 8 | Memory read byte, one cycle after address |
| regsOut | output | 128 | Eight general registers |
| ipOut | output | 16 | Instruction pointer |
| zfOut | output | 1 | Zero flag |
| sfOut | output | 1 | Sign flag |

## Verification
Two of this block's functions can fall in the same execute cycle. One is a byte-half read and a byte-half write of the same 16-bit register, as in adding AL into AH. The other is a read-modify-write of memory, where the operand read and the result store both target the same two bytes. The bench provokes both with directed records and also wraps a two-byte store and load across the top of memory. A behavioural model in the bench predicts the registers, pointer, flags, busy length, write count and full memory image for every instruction and compares them once the unit goes idle.

// File: rtl/exec16_pkg.sv
package exec16_pkg;
  localparam int WORD_W     = 16;
  localparam int BYTE_W     = 8;
  localparam int REG_SEL_W  = 3;
  localparam int NREG       = 1 << REG_SEL_W;
  localparam int INST_LEN_W = 3;

  typedef enum logic [2:0] {
    OP_MOV = 3'd0,
    OP_ADD = 3'd1,
    OP_SUB = 3'd2,
    OP_CMP = 3'd3,
    OP_JNE = 3'd4
  } opCode_t;

  typedef enum logic [1:0] {
    SRC_REG   = 2'd0,
    SRC_IMM8  = 2'd1,
    SRC_IMM16 = 2'd2,
    SRC_MEM   = 2'd3
  } srcKind_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RDLO, ST_RDHI, ST_EXEC, ST_WRLO, ST_WRHI
  } ctrlState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic latch;   // take a new record
    logic capLo;   // capture low read byte
    logic exec;    // compute and commit
    logic hiByte;  // address offset of one
    logic wrByte;  // write one byte
  } ctrlStrobe_t;

  typedef struct packed {
    opCode_t                 op;
    logic [INST_LEN_W-1:0]   len;
    logic                    dstIsReg;
    logic [REG_SEL_W:0]      dstReg;
    srcKind_t                kind;
    logic [REG_SEL_W:0]      srcReg;
    logic [WORD_W-1:0]       srcImm;
    logic [BYTE_W-1:0]       off;
  } instRec_t;
endpackage

// File: rtl/exec16_ctrl.sv
module exec16_ctrl
  import exec16_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        instValid,
  input  logic        newNeedRd,
  input  logic        needWr,
  input  logic        isWide,
  output ctrlStrobe_t strobe,
  output logic        busy
);
  ctrlState_t state, stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE: if (instValid) stateNext = newNeedRd ? ST_RDLO : ST_EXEC;
      ST_RDLO: stateNext = ST_RDHI;
      ST_RDHI: stateNext = ST_EXEC;
      ST_EXEC: stateNext = needWr ? ST_WRLO : ST_IDLE;
      ST_WRLO: stateNext = isWide ? ST_WRHI : ST_IDLE;
      ST_WRHI: stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_comb begin
    strobe        = '0;
    strobe.latch  = (state == ST_IDLE) && instValid;
    strobe.capLo  = (state == ST_RDHI);
    strobe.exec   = (state == ST_EXEC);
    strobe.hiByte = (state == ST_RDHI) || (state == ST_WRHI);
    strobe.wrByte = (state == ST_WRLO) || (state == ST_WRHI);
  end

  assign busy = (state != ST_IDLE);
endmodule

// File: rtl/exec16_dpath.sv
module exec16_dpath
  import exec16_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  ctrlStrobe_t             strobe,
  input  instRec_t                newInst,
  input  logic [ADDR_W-1:0]       newDstAddr,
  input  logic [ADDR_W-1:0]       newSrcAddr,
  output logic                    newNeedRd,
  output logic                    needWr,
  output logic                    isWide,
  output logic [ADDR_W-1:0]       memAddr,
  output logic [BYTE_W-1:0]       memWdata,
  input  logic [BYTE_W-1:0]       memRdata,
  output logic [NREG*WORD_W-1:0]  regsOut,
  output logic [WORD_W-1:0]       ipOut,
  output logic                    zfOut,
  output logic                    sfOut
);
  logic [NREG-1:0][WORD_W-1:0] gpr;
  instRec_t                    cur;
  logic [ADDR_W-1:0]           dstAddrQ, srcAddrQ;
  logic [BYTE_W-1:0]           loQ;
  logic [WORD_W-1:0]           resQ, ipQ;
  logic                        zfQ, sfQ;

  logic [WORD_W-1:0] memOp, dstVal, srcVal, rawRes, res;
  logic              zfNext, sfNext, setsFlags, writesReg, jneTaken;
  logic [ADDR_W-1:0] rdAddr, baseAddr;

  function automatic logic [WORD_W-1:0] pickReg(
    input logic [REG_SEL_W:0] code,
    input logic [NREG-1:0][WORD_W-1:0] f
  );
    logic [WORD_W-1:0] w;
    w = f[{1'b0, code[1:0]}];
    if (code[REG_SEL_W]) return f[code[REG_SEL_W-1:0]];
    else if (code[2])    return {{BYTE_W{1'b0}}, w[WORD_W-1:BYTE_W]};
    else                 return {{BYTE_W{1'b0}}, w[BYTE_W-1:0]};
  endfunction

  function automatic logic opReadsMem(input instRec_t r);
    logic arith;
    arith = (r.op == OP_ADD) || (r.op == OP_SUB) || (r.op == OP_CMP);
    return (r.op != OP_JNE) &&
           ((r.kind == SRC_MEM) || (!r.dstIsReg && arith));
  endfunction

  // record latch
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cur      <= '0;
      dstAddrQ <= '0;
      srcAddrQ <= '0;
    end else if (strobe.latch) begin
      cur      <= newInst;
      dstAddrQ <= newDstAddr;
      srcAddrQ <= newSrcAddr;
    end
  end

  assign newNeedRd = opReadsMem(newInst);
  assign needWr    = !cur.dstIsReg &&
                     ((cur.op == OP_MOV) || (cur.op == OP_ADD) || (cur.op == OP_SUB));

  // width selection
  always_comb begin
    if (cur.dstIsReg)            isWide = cur.dstReg[REG_SEL_W];
    else if (cur.kind == SRC_REG) isWide = cur.srcReg[REG_SEL_W];
    else                          isWide = (cur.kind == SRC_IMM16);
  end

  // operands and arithmetic
  always_comb begin
    memOp  = {isWide ? memRdata : {BYTE_W{1'b0}}, loQ};
    dstVal = cur.dstIsReg ? pickReg(cur.dstReg, gpr) : memOp;
    unique case (cur.kind)
      SRC_REG:   srcVal = pickReg(cur.srcReg, gpr);
      SRC_MEM:   srcVal = memOp;
      default:   srcVal = cur.srcImm;
    endcase
    unique case (cur.op)
      OP_MOV:  rawRes = srcVal;
      OP_ADD:  rawRes = dstVal + srcVal;
      default: rawRes = dstVal - srcVal;
    endcase
    res       = isWide ? rawRes : {{BYTE_W{1'b0}}, rawRes[BYTE_W-1:0]};
    zfNext    = (res == '0);
    sfNext    = isWide ? res[WORD_W-1] : res[BYTE_W-1];
    setsFlags = (cur.op == OP_ADD) || (cur.op == OP_SUB) || (cur.op == OP_CMP);
    writesReg = cur.dstIsReg &&
                ((cur.op == OP_MOV) || (cur.op == OP_ADD) || (cur.op == OP_SUB));
    jneTaken  = (cur.op == OP_JNE) && !zfQ;
  end

  // register file with byte-half merge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gpr <= '0;
    end else if (strobe.exec && writesReg) begin
      if (cur.dstReg[REG_SEL_W])
        gpr[cur.dstReg[REG_SEL_W-1:0]] <= res;
      else if (cur.dstReg[2])
        gpr[{1'b0, cur.dstReg[1:0]}][WORD_W-1:BYTE_W] <= res[BYTE_W-1:0];
      else
        gpr[{1'b0, cur.dstReg[1:0]}][BYTE_W-1:0] <= res[BYTE_W-1:0];
    end
  end

  // flags, pointer, captured bytes
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      zfQ  <= 1'b0;
      sfQ  <= 1'b0;
      ipQ  <= '0;
      loQ  <= '0;
      resQ <= '0;
    end else begin
      if (strobe.capLo) loQ <= memRdata;
      if (strobe.exec) begin
        resQ <= res;
        ipQ  <= ipQ + WORD_W'(cur.len) +
                (jneTaken ? {{(WORD_W-BYTE_W){cur.off[BYTE_W-1]}}, cur.off} : '0);
        if (setsFlags) begin
          zfQ <= zfNext;
          sfQ <= sfNext;
        end
      end
    end
  end

  // memory port
  assign rdAddr   = (cur.kind == SRC_MEM) ? srcAddrQ : dstAddrQ;
  assign baseAddr = strobe.wrByte ? dstAddrQ : rdAddr;
  assign memAddr  = baseAddr + ADDR_W'(strobe.hiByte);
  assign memWdata = strobe.hiByte ? resQ[WORD_W-1:BYTE_W] : resQ[BYTE_W-1:0];

  assign regsOut = gpr;
  assign ipOut   = ipQ;
  assign zfOut   = zfQ;
  assign sfOut   = sfQ;
endmodule

// File: rtl/exec16_top.sv
module exec16_top
  import exec16_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    instValid,
  input  logic [2:0]              instOp,
  input  logic [INST_LEN_W-1:0]   instLen,
  input  logic                    dstIsReg,
  input  logic [REG_SEL_W:0]      dstReg,
  input  logic [ADDR_W-1:0]       dstAddr,
  input  logic [1:0]              srcKind,
  input  logic [REG_SEL_W:0]      srcReg,
  input  logic [WORD_W-1:0]       srcImm,
  input  logic [ADDR_W-1:0]       srcAddr,
  input  logic [BYTE_W-1:0]       jmpOff,
  output logic                    busy,
  output logic [ADDR_W-1:0]       memAddr,
  output logic                    memWe,
  output logic [BYTE_W-1:0]       memWdata,
  input  logic [BYTE_W-1:0]       memRdata,
  output logic [NREG*WORD_W-1:0]  regsOut,
  output logic [WORD_W-1:0]       ipOut,
  output logic                    zfOut,
  output logic                    sfOut
);
  ctrlStrobe_t strobe;
  instRec_t    newInst;
  logic        newNeedRd, needWr, isWide;

  always_comb begin
    newInst.op       = opCode_t'(instOp);
    newInst.len      = instLen;
    newInst.dstIsReg = dstIsReg;
    newInst.dstReg   = dstReg;
    newInst.kind     = srcKind_t'(srcKind);
    newInst.srcReg   = srcReg;
    newInst.srcImm   = srcImm;
    newInst.off      = jmpOff;
  end

  exec16_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .instValid (instValid),
    .newNeedRd (newNeedRd),
    .needWr    (needWr),
    .isWide    (isWide),
    .strobe    (strobe),
    .busy      (busy)
  );

  exec16_dpath #(.ADDR_W(ADDR_W)) u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .newInst    (newInst),
    .newDstAddr (dstAddr),
    .newSrcAddr (srcAddr),
    .newNeedRd  (newNeedRd),
    .needWr     (needWr),
    .isWide     (isWide),
    .memAddr    (memAddr),
    .memWdata   (memWdata),
    .memRdata   (memRdata),
    .regsOut    (regsOut),
    .ipOut      (ipOut),
    .zfOut      (zfOut),
    .sfOut      (sfOut)
  );

  assign memWe = strobe.wrByte;
endmodule

// File: rtl/exec16_chk.sv
module exec16_chk #(
  parameter int ADDR_W = 11
) (
  input logic              clk,
  input logic              rstN,
  input logic              busy,
  input logic              memWe,
  input logic [ADDR_W-1:0] memAddr,
  input logic [127:0]      regsOut,
  input logic [15:0]       ipOut,
  input logic              zfOut,
  input logic              sfOut
);
  AST_WE_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> busy); // R7

  AST_WR_ADDR_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (memWe && $past(memWe)) |-> (memAddr == ADDR_W'($past(memAddr) + 1'b1))); // R8

  AST_IP_MOVES_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(ipOut) |-> $past(busy)); // R6

  AST_REGS_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !busy |=> $stable(regsOut)); // R9

  AST_FLAGS_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !busy |=> $stable({zfOut, sfOut})); // R5
endmodule

bind exec16_top exec16_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .busy    (busy),
  .memWe   (memWe),
  .memAddr (memAddr),
  .regsOut (regsOut),
  .ipOut   (ipOut),
  .zfOut   (zfOut),
  .sfOut   (sfOut)
);

// File: tb/test_exec16_top.sv
module test_exec16_top;
  localparam int ADDR_W = 11;
  localparam int MEM_SZ = 1 << ADDR_W;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic              rstN;
  logic              instValid;
  logic [2:0]        instOp;
  logic [2:0]        instLen;
  logic              dstIsReg;
  logic [3:0]        dstReg;
  logic [ADDR_W-1:0] dstAddr;
  logic [1:0]        srcKind;
  logic [3:0]        srcReg;
  logic [15:0]       srcImm;
  logic [ADDR_W-1:0] srcAddr;
  logic [7:0]        jmpOff;
  logic              busy;
  logic [ADDR_W-1:0] memAddr;
  logic              memWe;
  logic [7:0]        memWdata;
  logic [7:0]        memRdata;
  logic [127:0]      regsOut;
  logic [15:0]       ipOut;
  logic              zfOut, sfOut;

  exec16_top #(.ADDR_W(ADDR_W)) i_exec16_top (
    .clk(clk), .rstN(rstN), .instValid(instValid), .instOp(instOp),
    .instLen(instLen), .dstIsReg(dstIsReg), .dstReg(dstReg), .dstAddr(dstAddr),
    .srcKind(srcKind), .srcReg(srcReg), .srcImm(srcImm), .srcAddr(srcAddr),
    .jmpOff(jmpOff), .busy(busy), .memAddr(memAddr), .memWe(memWe),
    .memWdata(memWdata), .memRdata(memRdata), .regsOut(regsOut),
    .ipOut(ipOut), .zfOut(zfOut), .sfOut(sfOut)
  );

  // device memory, one-cycle read
  logic [7:0] devMem [MEM_SZ];
  logic [7:0] refMem [MEM_SZ];
  always @(posedge clk) begin
    if (memWe) devMem[memAddr] <= memWdata;
    memRdata <= devMem[memAddr];
  end

  // reference state
  int refReg [8];
  int refIp, refZf, refSf;
  int checks = 0, errors = 0;

  function automatic int getR(int code);
    int w;
    w = refReg[code & 3];
    if (code & 8) return refReg[code & 7];
    if (code & 4) return (w >> 8) & 8'hFF;
    return w & 8'hFF;
  endfunction

  task automatic setR(int code, int v);
    int i;
    i = code & 3;
    if (code & 8)      refReg[code & 7] = v & 16'hFFFF;
    else if (code & 4) refReg[i] = (refReg[i] & 16'h00FF) | ((v & 8'hFF) << 8);
    else               refReg[i] = (refReg[i] & 16'hFF00) | (v & 8'hFF);
  endtask

  function automatic int rdMem(int a, int wide);
    int lo, hi;
    lo = refMem[a % MEM_SZ];
    hi = wide ? refMem[(a + 1) % MEM_SZ] : 0;
    return lo | (hi << 8);
  endfunction

  task automatic chk(string what, logic [127:0] got, logic [127:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", what, got, exp);
    end
  endtask

  task automatic chkState(string tag);
    logic [127:0] e;
    int bad;
    for (int i = 0; i < 8; i++) e[i*16 +: 16] = refReg[i][15:0];
    chk({tag, " registers"}, regsOut, e);
    chk({tag, " ip"}, 128'(ipOut), 128'(refIp));
    chk({tag, " flags zf,sf"}, 128'({zfOut, sfOut}), 128'({refZf[0], refSf[0]}));
    bad = 0;
    for (int i = 0; i < MEM_SZ; i++) if (devMem[i] !== refMem[i]) bad++;
    chk({tag, " memory mismatches"}, 128'(bad), 128'(0));
  endtask

  // issue one record, model it, wait for idle, compare
  task automatic run(string tag, int op, int len, int dIsReg, int dReg, int dAddr,
                     int sKind, int sReg, int sImm, int sAddr, int off, int junk);
    int wide, mask, dv, sv, res, rdNeed, wrNeed, busyExp, weExp, busyCnt, weCnt;
    while (busy) @(negedge clk);
    instValid = 1'b1; instOp = 3'(op); instLen = 3'(len);
    dstIsReg = dIsReg[0]; dstReg = 4'(dReg); dstAddr = ADDR_W'(dAddr);
    srcKind = 2'(sKind); srcReg = 4'(sReg); srcImm = 16'(sImm);
    srcAddr = ADDR_W'(sAddr); jmpOff = 8'(off);
    // model
    if (dIsReg) wide = (dReg >> 3) & 1;
    else if (sKind == 0) wide = (sReg >> 3) & 1;
    else wide = (sKind == 2);
    mask = wide ? 16'hFFFF : 8'hFF;
    dv = dIsReg ? getR(dReg) : rdMem(dAddr, wide);
    case (sKind)
      0: sv = getR(sReg);
      3: sv = rdMem(sAddr, wide);
      default: sv = sImm & 16'hFFFF;
    endcase
    case (op)
      0: res = sv;
      1: res = dv + sv;
      default: res = dv - sv;
    endcase
    res = res & mask;
    if (op >= 1 && op <= 3) begin
      refZf = (res == 0);
      refSf = wide ? (res >> 15) & 1 : (res >> 7) & 1;
    end
    wrNeed = (!dIsReg && op <= 2);
    if (op <= 2) begin
      if (dIsReg) setR(dReg, res);
      else begin
        refMem[dAddr % MEM_SZ] = 8'(res);
        if (wide) refMem[(dAddr + 1) % MEM_SZ] = 8'(res >> 8);
      end
    end
    refIp = (refIp + len) & 16'hFFFF;
    if (op == 4 && refZf == 0) refIp = (refIp + int'($signed(8'(off)))) & 16'hFFFF;
    rdNeed  = (op != 4) && (sKind == 3 || (!dIsReg && op >= 1 && op <= 3));
    weExp   = wrNeed ? (wide ? 2 : 1) : 0;
    busyExp = 1 + (rdNeed ? 2 : 0) + weExp;
    @(negedge clk);
    if (junk) begin
      // a different record held valid while busy must be ignored
      instOp = 3'd0; instLen = 3'd3; dstIsReg = 1'b1; dstReg = 4'd8;
      srcKind = 2'd2; srcImm = 16'hDEAD;
    end else instValid = 1'b0;
    busyCnt = 0; weCnt = 0;
    while (busy) begin
      busyCnt++;
      if (memWe) weCnt++;
      @(negedge clk);
    end
    instValid = 1'b0;
    chk({tag, " busy cycles (R9)"}, 128'(busyCnt), 128'(busyExp));
    chk({tag, " write bytes (R7)"}, 128'(weCnt), 128'(weExp));
    chkState(tag);
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    int guard;
    rstN = 1'b0; instValid = 1'b0; instOp = '0; instLen = '0; dstIsReg = 1'b0;
    dstReg = '0; dstAddr = '0; srcKind = '0; srcReg = '0; srcImm = '0;
    srcAddr = '0; jmpOff = '0;
    for (int i = 0; i < MEM_SZ; i++) begin
      devMem[i] = 8'((i * 37 + 11) & 8'hFF);
      refMem[i] = devMem[i];
    end
    for (int i = 0; i < 8; i++) refReg[i] = 0;
    refIp = 0; refZf = 0; refSf = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 busy/memWe at reset", 128'({busy, memWe}), 128'(0));
    chkState("R1 reset");
    rstN = 1'b1;
    @(negedge clk);

    // R3 wide immediate into AX (code 8)
    run("R3 mov ax,imm16", 0, 3, 1, 8, 0, 2, 0, 16'h1234, 0, 0, 0);
    // R2 high byte AH (code 4) keeps AL
    run("R2 mov ah,imm8", 0, 2, 1, 4, 0, 1, 0, 8'hAB, 0, 0, 0);
    // R2 R5 add AH,AL: half read and half write of one register, sign from bit 7
    run("R2 add ah,al", 1, 2, 1, 4, 0, 0, 0, 0, 0, 0, 0);
    // R5 8-bit truncation gives zero while BH untouched
    run("R5 mov bx,imm16", 0, 3, 1, 11, 0, 2, 0, 16'h12FF, 0, 0, 0);
    run("R5 add bl,1", 1, 3, 1, 3, 0, 1, 0, 1, 0, 0, 0);
    // R4 compare leaves BX, sets ZF
    run("R4 cmp bx,imm16", 3, 4, 1, 11, 0, 2, 0, 16'h1200, 0, 0, 0);
    run("R6 jne not taken", 4, 2, 1, 8, 0, 1, 0, 0, 0, 8'hFC, 0);
    // R5 sub wraps to negative, R6 taken branch backwards
    run("R5 sub cx,1", 2, 4, 1, 9, 0, 2, 0, 1, 0, 0, 0);
    run("R4 mov keeps flags", 0, 3, 1, 15, 0, 2, 0, 0, 0, 0, 0);
    run("R6 jne taken", 4, 2, 1, 8, 0, 1, 0, 0, 0, 8'hF0, 0);
    // R7 stores
    run("R7 mov word mem", 0, 6, 0, 0, 1000, 2, 0, 16'hBEEF, 0, 0, 0);
    run("R7 mov byte mem", 0, 5, 0, 0, 1002, 1, 0, 8'h55, 0, 0, 0);
    // R10 little-endian load
    run("R10 mov dx,word mem", 0, 4, 1, 10, 0, 3, 0, 0, 1000, 0, 0);
    // R4 read-modify-write on memory, width from source register
    run("R4 add mem,dx", 1, 4, 0, 0, 1000, 0, 10, 0, 0, 0, 0);
    run("R5 cmp byte mem,imm8", 3, 5, 0, 0, 1002, 1, 0, 8'h55, 0, 0, 0);
    // R8 wrap at top of memory
    run("R8 mov word mem wrap", 0, 6, 0, 0, MEM_SZ - 1, 2, 0, 16'hA55A, 0, 0, 0);
    run("R8 mov si,word mem wrap", 0, 4, 1, 14, 0, 3, 0, 0, MEM_SZ - 1, 0, 0);
    // R9 valid held during busy is ignored
    run("R9 ignore while busy", 0, 6, 0, 0, 200, 2, 0, 16'h1357, 0, 0, 1);

    // R11 store loop then sum loop
    run("R11 mov dx,6", 0, 3, 1, 10, 0, 2, 0, 6, 0, 0, 0);
    run("R11 mov bp,1000", 0, 3, 1, 13, 0, 2, 0, 1000, 0, 0, 0);
    run("R11 mov si,0", 0, 3, 1, 14, 0, 2, 0, 0, 0, 0, 0);
    guard = 0;
    do begin
      run("R11 store", 0, 2, 0, 0, (refReg[5] + refReg[6]) % MEM_SZ, 0, 14, 0, 0, 0, 0);
      run("R11 add si,2", 1, 3, 1, 14, 0, 1, 0, 2, 0, 0, 0);
      run("R11 cmp si,dx", 3, 2, 1, 14, 0, 0, 10, 0, 0, 0, 0);
      run("R11 jne", 4, 2, 1, 8, 0, 1, 0, 0, 0, 8'hF9, 0);
      guard++;
    end while (refZf == 0 && guard < 10);
    run("R11 mov bx,0", 0, 3, 1, 11, 0, 2, 0, 0, 0, 0, 0);
    run("R11 mov si,0", 0, 3, 1, 14, 0, 2, 0, 0, 0, 0, 0);
    guard = 0;
    do begin
      run("R11 load", 0, 2, 1, 9, 0, 3, 0, 0, (refReg[5] + refReg[6]) % MEM_SZ, 0, 0);
      run("R11 add bx,cx", 1, 2, 1, 11, 0, 0, 9, 0, 0, 0, 0);
      run("R11 add si,2", 1, 3, 1, 14, 0, 1, 0, 2, 0, 0, 0);
      run("R11 cmp si,dx", 3, 2, 1, 14, 0, 0, 10, 0, 0, 0, 0);
      run("R11 jne", 4, 2, 1, 8, 0, 1, 0, 0, 0, 8'hF7, 0);
      guard++;
    end while (refZf == 0 && guard < 10);
    chk("R11 final bx", 128'(regsOut[3*16 +: 16]), 128'(6));
    chk("R11 final si", 128'(regsOut[6*16 +: 16]), 128'(6));
    chk("R11 final zf", 128'(zfOut), 128'(1));

    summary();
    $finish;
  end
endmodule